// File: doc/BRIEF.md
# Masked Reference Stream Comparator

This block checks a stream of captured samples against a stored known-good sample stream, one sample per accepted cycle. Live samples and reference samples advance together: the block drives the read address of an external reference memory and expects the addressed word back one clock later, so it holds the live word for one stage to line the two up. A per-bit mask chooses which signals or bus fields take part in the check. For every compared sample the block reports whether any selected bit differs, and it reports the masked XOR vector so that each differing bit can be found.

Each run compares `cfg_last + 1` samples, numbered from zero. The block counts mismatching samples, not mismatching bits. When a nonzero difference limit is reached it halts at once, drops its capture-enable output and ignores the rest of the stream. It keeps the index of the first mismatching sample and of the sample that reached the limit. A limit of zero disables halting. Every run ends with a one-cycle done pulse and a pass flag that is set only when no sample differed. With repeat mode on, the block re-arms by itself after each complete run, so every new acquisition is compared from index zero against the same reference.

Top module: `golden_cmp`

## Requirements
- R1: `cmp_mismatch` is 1 for a sample exactly when `(live ^ reference) & cfg_mask` is nonzero. Differences on bits whose mask bit is 0 never set it.
- R2: `cmp_diff` equals `(live ^ reference) & cfg_mask`, with bit i standing for signal i. `cmp_valid`, `cmp_mismatch` and `cmp_diff` for a sample accepted on clock edge k are presented after edge k+1.
- R3: `diff_count` grows by exactly one for each mismatching sample, however many bits differ, and it is cleared when a run starts.
- R4: With `cfg_limit` nonzero, the sample that brings `diff_count` to `cfg_limit` halts the run. `halted` goes to 1, no later sample of that run is accepted or reported, and `diff_count` stays at the limit.
- R5: With `cfg_limit` = 0 the block never halts, and every sample of the run is compared and counted.
- R6: `first_idx` holds the index of the first mismatching sample of the run. `hit_idx` holds the index of the sample that reached the limit.
- R7: `ref_addr` presents the index of the next sample to be accepted, and `ref_data` is taken one cycle later. A cycle with `live_valid` low does not advance the index. A run covers samples 0 to `cfg_last`.
- R8: With `cfg_repeat` = 1, a run that ends without halting returns to the armed state, and the next `run_start` compares again from index 0 with no `arm` needed. With `cfg_repeat` = 0 the block goes idle, and it ignores `run_start` until `arm`.
- R9: `run_done` pulses for one cycle together with the result of the last sample, or of the halting sample. `run_pass` is 1 then exactly when the run found no mismatch.
- R10: `capture_active` is 1 from the edge that accepts `run_start` until the last sample is accepted or the run halts.
- R11: After reset, `capture_active`, `cmp_valid`, `diff_count`, `halted`, `run_done` and `ref_addr` are all 0.
- R12: `live_valid` outside an active run is ignored: it produces no `cmp_valid` and does not change `diff_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mask | input | W | Bits that take part in the comparison |
| cfg_limit | input | CW | Mismatching samples that halt a run (0 = never) |
| cfg_last | input | AW | Index of the last sample of a run |
| cfg_repeat | input | 1 | Re-arm automatically after each complete run |
| arm | input | 1 | Move from idle to armed |
| run_start | input | 1 | Begin a run when armed |
| live_valid | input | 1 | Live sample present |
| live_data | input | W | Live sample |
| ref_addr | output | AW | Read address into the reference memory |
| ref_data | input | W | Reference word, one cycle after its address |
| capture_active | output | 1 | Run is accepting samples |
| cmp_valid | output | 1 | A comparison result is presented |
| cmp_mismatch | output | 1 | The presented sample differs on a masked bit |
| cmp_diff | output | W | Masked XOR difference vector |
| diff_count | output | CW | Mismatching samples in this run |
| first_idx | output | AW | Index of the first mismatching sample |
| hit_idx | output | AW | Index of the sample that reached the limit |
| halted | output | 1 | The run stopped on the limit |
| run_done | output | 1 | One-cycle end-of-run pulse |
| run_pass | output | 1 | The last finished run had no mismatch |

## Verification
The bench inserts idle cycles into the live stream. A design that advanced the reference address on every cycle, or that compared the live word against a reference word from the wrong cycle, would then report mismatches on a clean stream. It sets differences only on bits outside the mask, and it sets samples with many differing bits. A design that did not apply the mask, or that counted bits instead of samples, would report the wrong mismatch flags and the wrong count. It drives samples past a halting point and also puts the limit on the last sample. A stop decided one stage late would let extra results through, and a wrong comparison against the limit would halt early, halt late, or with a limit of zero halt at once. It runs back to back in repeat mode and single mode. A design that did not reset the index to zero would compare against shifted reference data. A design that ignored the repeat setting would accept or refuse the second start wrongly.

// File: rtl/golden_cmp_pkg.sv
package golden_cmp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } gc_state_e;
endpackage

// File: rtl/gc_seq.sv
// Run sequencer: owns the sample index, the reference address and the
// one-stage live holding register that lines up with the memory latency.
module gc_seq
  import golden_cmp_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          run_start,
  input  logic          cfg_repeat,
  input  logic [AW-1:0] cfg_last,
  input  logic          live_valid,
  input  logic [W-1:0]  live_data,
  input  logic          stop_hit,
  output logic [AW-1:0] ref_addr,
  output logic          s1_valid,
  output logic [W-1:0]  s1_data,
  output logic [AW-1:0] s1_idx,
  output logic          s1_last,
  output logic          run_clear,
  output logic          capture_active
);
  gc_state_e     state;
  logic [AW-1:0] idx;
  logic          accept;
  logic          at_last;

  assign at_last        = (idx == cfg_last);
  assign accept         = (state == ST_RUN) && live_valid && !stop_hit;
  assign run_clear      = (state == ST_ARMED) && run_start;
  assign ref_addr       = idx;
  assign capture_active = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx      <= '0;
      s1_valid <= 1'b0;
      s1_data  <= '0;
      s1_idx   <= '0;
      s1_last  <= 1'b0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_data <= live_data;
        s1_idx  <= idx;
        s1_last <= at_last;
      end
      unique case (state)
        ST_IDLE: if (arm) state <= ST_ARMED;
        ST_ARMED: begin
          if (run_start) begin
            state <= ST_RUN;
            idx   <= '0;
          end
        end
        ST_RUN: begin
          if (stop_hit) state <= ST_IDLE;
          else if (accept) begin
            if (at_last) state <= ST_DRAIN;
            else         idx   <= idx + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (stop_hit)        state <= ST_IDLE;
          else if (cfg_repeat) state <= ST_ARMED;
          else                 state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: every accepted non-final sample moves the reference address by one
  p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
    (capture_active && live_valid && !stop_hit && ref_addr != cfg_last)
      |=> ref_addr == $past(ref_addr) + 1'b1);

  // R7: an idle cycle leaves the address where it was
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (capture_active && !live_valid) |=> $stable(ref_addr));

  // R8: every run begins at index zero
  p_restart_zero_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(capture_active) |-> ref_addr == '0);

  // R12: nothing enters the compare stage outside an active run
  p_idle_ignore_r12: assert property (@(posedge clk) disable iff (rst)
    !capture_active |=> !s1_valid);
endmodule

// File: rtl/gc_diff.sv
// Masked XOR stage: compares the held live word with the reference word
// returned by the memory and registers the result for the outputs.
module gc_diff #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s1_valid,
  input  logic [W-1:0] s1_data,
  input  logic [W-1:0] ref_data,
  input  logic [W-1:0] cfg_mask,
  output logic         mism_c,
  output logic         cmp_valid,
  output logic         cmp_mismatch,
  output logic [W-1:0] cmp_diff
);
  logic [W-1:0] diff_c;

  assign diff_c = (s1_data ^ ref_data) & cfg_mask;
  assign mism_c = s1_valid && (diff_c != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_valid    <= 1'b0;
      cmp_mismatch <= 1'b0;
      cmp_diff     <= '0;
    end else begin
      cmp_valid <= s1_valid;
      if (s1_valid) begin
        cmp_mismatch <= mism_c;
        cmp_diff     <= diff_c;
      end
    end
  end

  // R2: no reported difference bit lies outside the mask
  p_diff_in_mask_r2: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |-> (cmp_diff & ~$past(cfg_mask)) == '0);

  // R1: the flag agrees with the vector it is reported with
  p_flag_matches_r1: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |-> cmp_mismatch == (cmp_diff != '0));
endmodule

// File: rtl/gc_tally.sv
// Difference counter, limit check, index capture and end-of-run status.
module gc_tally #(
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          eval,
  input  logic          mism,
  input  logic [AW-1:0] s_idx,
  input  logic          s_last,
  input  logic [CW-1:0] cfg_limit,
  output logic          stop_hit,
  output logic [CW-1:0] diff_count,
  output logic [AW-1:0] first_idx,
  output logic [AW-1:0] hit_idx,
  output logic          halted,
  output logic          run_done,
  output logic          run_pass
);
  logic          inc;
  logic [CW-1:0] cnt_nx;

  assign inc      = eval && mism;
  assign cnt_nx   = diff_count + {{(CW-1){1'b0}}, inc};
  assign stop_hit = inc && (cfg_limit != '0) && (cnt_nx == cfg_limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      diff_count <= '0;
      first_idx  <= '0;
      hit_idx    <= '0;
      halted     <= 1'b0;
      run_done   <= 1'b0;
      run_pass   <= 1'b0;
    end else begin
      run_done <= 1'b0;
      if (clear) begin
        diff_count <= '0;
        first_idx  <= '0;
        hit_idx    <= '0;
        halted     <= 1'b0;
      end else if (eval) begin
        diff_count <= cnt_nx;
        if (inc && diff_count == '0) first_idx <= s_idx;
        if (stop_hit) begin
          halted  <= 1'b1;
          hit_idx <= s_idx;
        end
        if (s_last || stop_hit) begin
          run_done <= 1'b1;
          run_pass <= (cnt_nx == '0);
        end
      end
    end
  end

  // R3: the count moves by at most one sample per cycle within a run
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(clear) |-> (diff_count == $past(diff_count)) ||
                      (diff_count == $past(diff_count) + CW'(1)));

  // R4: halting happens exactly at the programmed limit
  p_stop_at_limit_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> diff_count == $past(cfg_limit));

  // R5: a zero limit never halts
  p_zero_never_stops_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> $past(cfg_limit) != '0);

  // R9: pass flag reflects an empty difference count
  p_pass_r9: assert property (@(posedge clk) disable iff (rst)
    run_done |-> run_pass == (diff_count == '0));

  // R6: the first mismatch never comes after the halting one
  p_first_le_hit_r6: assert property (@(posedge clk) disable iff (rst)
    halted |-> first_idx <= hit_idx);
endmodule

// File: rtl/golden_cmp.sv
module golden_cmp #(
  parameter int W  = 16,
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  cfg_mask,
  input  logic [CW-1:0] cfg_limit,
  input  logic [AW-1:0] cfg_last,
  input  logic          cfg_repeat,
  input  logic          arm,
  input  logic          run_start,
  input  logic          live_valid,
  input  logic [W-1:0]  live_data,
  output logic [AW-1:0] ref_addr,
  input  logic [W-1:0]  ref_data,
  output logic          capture_active,
  output logic          cmp_valid,
  output logic          cmp_mismatch,
  output logic [W-1:0]  cmp_diff,
  output logic [CW-1:0] diff_count,
  output logic [AW-1:0] first_idx,
  output logic [AW-1:0] hit_idx,
  output logic          halted,
  output logic          run_done,
  output logic          run_pass
);
  logic          stop_hit;
  logic          s1_valid;
  logic [W-1:0]  s1_data;
  logic [AW-1:0] s1_idx;
  logic          s1_last;
  logic          run_clear;
  logic          mism_c;

  gc_seq #(.W(W), .AW(AW)) u_seq (
    .clk            (clk),
    .rst            (rst),
    .arm            (arm),
    .run_start      (run_start),
    .cfg_repeat     (cfg_repeat),
    .cfg_last       (cfg_last),
    .live_valid     (live_valid),
    .live_data      (live_data),
    .stop_hit       (stop_hit),
    .ref_addr       (ref_addr),
    .s1_valid       (s1_valid),
    .s1_data        (s1_data),
    .s1_idx         (s1_idx),
    .s1_last        (s1_last),
    .run_clear      (run_clear),
    .capture_active (capture_active)
  );

  gc_diff #(.W(W)) u_diff (
    .clk          (clk),
    .rst          (rst),
    .s1_valid     (s1_valid),
    .s1_data      (s1_data),
    .ref_data     (ref_data),
    .cfg_mask     (cfg_mask),
    .mism_c       (mism_c),
    .cmp_valid    (cmp_valid),
    .cmp_mismatch (cmp_mismatch),
    .cmp_diff     (cmp_diff)
  );

  gc_tally #(.AW(AW), .CW(CW)) u_tally (
    .clk        (clk),
    .rst        (rst),
    .clear      (run_clear),
    .eval       (s1_valid),
    .mism       (mism_c),
    .s_idx      (s1_idx),
    .s_last     (s1_last),
    .cfg_limit  (cfg_limit),
    .stop_hit   (stop_hit),
    .diff_count (diff_count),
    .first_idx  (first_idx),
    .hit_idx    (hit_idx),
    .halted     (halted),
    .run_done   (run_done),
    .run_pass   (run_pass)
  );

  // R4: once halted for more than a cycle, no result is reported
  p_quiet_after_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (halted && $past(halted)) |-> !cmp_valid);

  // R10: capture is off whenever the run has halted
  p_capture_off_halted_r10: assert property (@(posedge clk) disable iff (rst)
    halted |-> !capture_active);
endmodule

// File: tb/tb_golden_cmp.sv
module tb_golden_cmp;
  localparam int W  = 16;
  localparam int AW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [W-1:0]  cfg_mask;
  logic [CW-1:0] cfg_limit;
  logic [AW-1:0] cfg_last;
  logic          cfg_repeat;
  logic          arm, run_start, live_valid;
  logic [W-1:0]  live_data;
  logic [AW-1:0] ref_addr;
  logic [W-1:0]  ref_data;
  logic          capture_active, cmp_valid, cmp_mismatch;
  logic [W-1:0]  cmp_diff;
  logic [CW-1:0] diff_count;
  logic [AW-1:0] first_idx, hit_idx;
  logic          halted, run_done, run_pass;

  int total = 0;
  int bad   = 0;

  logic [W-1:0] err_pat [0:63];
  logic         ev_mism [0:63];
  logic [W-1:0] ev_diff [0:63];
  int           ev_n = 0;
  logic         dn_pass [0:7];
  int           dn_cnt  [0:7];
  int           dn_n = 0;

  always #5 clk = ~clk;

  golden_cmp #(.W(W), .AW(AW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .cfg_mask(cfg_mask), .cfg_limit(cfg_limit),
    .cfg_last(cfg_last), .cfg_repeat(cfg_repeat), .arm(arm),
    .run_start(run_start), .live_valid(live_valid), .live_data(live_data),
    .ref_addr(ref_addr), .ref_data(ref_data), .capture_active(capture_active),
    .cmp_valid(cmp_valid), .cmp_mismatch(cmp_mismatch), .cmp_diff(cmp_diff),
    .diff_count(diff_count), .first_idx(first_idx), .hit_idx(hit_idx),
    .halted(halted), .run_done(run_done), .run_pass(run_pass)
  );

  function automatic logic [W-1:0] ref_of(int i);
    return W'(i * 16'h1357) ^ 16'hA5A5;
  endfunction

  // reference memory with one cycle read latency
  always_ff @(posedge clk) ref_data <= ref_of(int'(ref_addr));

  // result collector, sampled just after each rising edge
  always begin
    @(posedge clk);
    #1;
    if (cmp_valid && ev_n < 64) begin
      ev_mism[ev_n] = cmp_mismatch;
      ev_diff[ev_n] = cmp_diff;
      ev_n++;
    end
    if (run_done && dn_n < 8) begin
      dn_pass[dn_n] = run_pass;
      dn_cnt[dn_n]  = int'(diff_count);
      dn_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    ev_n = 0;
    dn_n = 0;
    for (int i = 0; i < 64; i++) err_pat[i] = '0;
  endtask

  task automatic arm_and_start();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
  endtask

  task automatic play(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        live_valid = 1'b0;
        @(negedge clk);
      end
      live_valid = 1'b1;
      live_data  = ref_of(i) ^ err_pat[i];
      @(negedge clk);
    end
    live_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_events(input int n, input logic [W-1:0] mask);
    chk(ev_n == n, "R2 result count", ev_n, n);
    for (int k = 0; k < n && k < ev_n; k++) begin
      chk(ev_diff[k] == (err_pat[k] & mask), "R2 diff vector",
          int'(ev_diff[k]), int'(err_pat[k] & mask));
      chk(ev_mism[k] == ((err_pat[k] & mask) != '0), "R1 mismatch flag",
          int'(ev_mism[k]), int'((err_pat[k] & mask) != '0));
    end
  endtask

  task automatic t_reset();
    chk(capture_active == 1'b0, "R11 capture_active", capture_active, 0);
    chk(cmp_valid == 1'b0, "R11 cmp_valid", cmp_valid, 0);
    chk(diff_count == '0, "R11 diff_count", int'(diff_count), 0);
    chk(halted == 1'b0, "R11 halted", halted, 0);
    chk(run_done == 1'b0, "R11 run_done", run_done, 0);
    chk(ref_addr == '0, "R11 ref_addr", int'(ref_addr), 0);
  endtask

  task automatic t_clean();
    clear_log();
    cfg_mask = '1; cfg_limit = '0; cfg_last = 8'd9; cfg_repeat = 1'b0;
    arm_and_start();
    chk(capture_active == 1'b1, "R10 active after start", capture_active, 1);
    play(10, 1'b1);
    check_events(10, cfg_mask);
    chk(dn_n == 1, "R9 one done pulse", dn_n, 1);
    chk(dn_pass[0] == 1'b1, "R9 pass on clean run", dn_pass[0], 1);
    chk(diff_count == '0, "R3 clean count", int'(diff_count), 0);
    chk(capture_active == 1'b0, "R10 inactive after last", capture_active, 0);
  endtask

  task automatic t_masked();
    clear_log();
    cfg_mask = 16'h00FF; cfg_limit = '0; cfg_last = 8'd9; cfg_repeat = 1'b0;
    err_pat[2] = 16'h0100;
    err_pat[5] = 16'h0081;
    err_pat[7] = 16'hFF02;
    err_pat[8] = 16'h00FF;
    arm_and_start();
    play(10, 1'b1);
    check_events(10, cfg_mask);
    chk(diff_count == 16'd3, "R3 samples not bits", int'(diff_count), 3);
    chk(first_idx == 8'd5, "R6 first index", int'(first_idx), 5);
    chk(dn_n == 1 && dn_pass[0] == 1'b0, "R9 fail flag", dn_pass[0], 0);
  endtask

  task automatic t_limit();
    clear_log();
    cfg_mask = '1; cfg_limit = 16'd3; cfg_last = 8'd11; cfg_repeat = 1'b1;
    err_pat[1] = 16'h0001; err_pat[4] = 16'h8000; err_pat[6] = 16'h0F0F;
    err_pat[8] = 16'h0002; err_pat[9] = 16'h0004;
    arm_and_start();
    play(12, 1'b0);
    check_events(7, cfg_mask);
    chk(halted == 1'b1, "R4 halted", halted, 1);
    chk(diff_count == 16'd3, "R4 count held at limit", int'(diff_count), 3);
    chk(first_idx == 8'd1, "R6 first index", int'(first_idx), 1);
    chk(hit_idx == 8'd6, "R6 hit index", int'(hit_idx), 6);
    chk(capture_active == 1'b0, "R10 off on halt", capture_active, 0);
    chk(dn_n == 1 && dn_cnt[0] == 3, "R9 done on halt", dn_cnt[0], 3);
    // halted run does not re-arm even in repeat mode
    run_start = 1'b1; @(negedge clk); run_start = 1'b0; @(negedge clk);
    chk(capture_active == 1'b0, "R8 no restart after halt", capture_active, 0);
  endtask

  task automatic t_limit_last();
    clear_log();
    cfg_mask = '1; cfg_limit = 16'd2; cfg_last = 8'd11; cfg_repeat = 1'b0;
    err_pat[3] = 16'h0010; err_pat[11] = 16'h0100;
    arm_and_start();
    play(12, 1'b1);
    check_events(12, cfg_mask);
    chk(halted == 1'b1, "R4 halt on last sample", halted, 1);
    chk(hit_idx == 8'd11, "R6 hit on last sample", int'(hit_idx), 11);
    chk(dn_n == 1, "R9 single done at last", dn_n, 1);
  endtask

  task automatic t_limit_zero();
    clear_log();
    cfg_mask = '1; cfg_limit = '0; cfg_last = 8'd11; cfg_repeat = 1'b0;
    for (int i = 0; i < 12; i++) err_pat[i] = 16'h0001 << (i % 16);
    arm_and_start();
    play(12, 1'b0);
    check_events(12, cfg_mask);
    chk(halted == 1'b0, "R5 never halts", halted, 0);
    chk(diff_count == 16'd12, "R5 all counted", int'(diff_count), 12);
  endtask

  task automatic t_repeat();
    clear_log();
    cfg_mask = '1; cfg_limit = '0; cfg_last = 8'd5; cfg_repeat = 1'b1;
    err_pat[2] = 16'h4000;
    arm_and_start();
    play(6, 1'b0);
    chk(dn_n == 1 && dn_pass[0] == 1'b0, "R9 first run fails", dn_pass[0], 0);
    err_pat[2] = '0;
    ev_n = 0;
    run_start = 1'b1; @(negedge clk); run_start = 1'b0;
    chk(capture_active == 1'b1, "R8 restart without arm", capture_active, 1);
    play(6, 1'b1);
    check_events(6, cfg_mask);
    chk(dn_n == 2 && dn_pass[1] == 1'b1, "R8 second run from index 0", dn_pass[1], 1);
    chk(diff_count == '0, "R3 cleared at run start", int'(diff_count), 0);
  endtask

  task automatic t_single_idle();
    clear_log();
    cfg_repeat = 1'b0; cfg_last = 8'd3; cfg_limit = '0; cfg_mask = '1;
    arm_and_start();
    play(4, 1'b0);
    ev_n = 0;
    // now idle: start alone and stray samples must do nothing
    run_start = 1'b1; @(negedge clk); run_start = 1'b0;
    chk(capture_active == 1'b0, "R8 start ignored when idle", capture_active, 0);
    err_pat[0] = 16'hFFFF;
    play(3, 1'b0);
    chk(ev_n == 0, "R12 idle samples ignored", ev_n, 0);
    chk(diff_count == '0, "R12 count untouched", int'(diff_count), 0);
    arm = 1'b1; @(negedge clk); arm = 1'b0;
    play(3, 1'b0);
    chk(ev_n == 0, "R12 armed samples ignored", ev_n, 0);
  endtask

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; arm = 1'b0; run_start = 1'b0; live_valid = 1'b0;
    live_data = '0; cfg_mask = '1; cfg_limit = '0; cfg_last = '0;
    cfg_repeat = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_masked();
    t_limit();
    t_limit_last();
    t_limit_zero();
    t_repeat();
    t_single_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule